// File: doc/BRIEF.md
# Task-State Switch Validity Checker

This block screens an incoming task state during a protected-mode task switch before any of its segment state is loaded. A start pulse captures the task-state segment limit, the global descriptor table limit, an "external event in progress" flag and the seven selectors held in the incoming task state. The block then visits those selectors one after another in a fixed order. For each selector it first screens the selector itself (null test, table choice, bounds) and then reads its descriptor through a simple request/acknowledge table port and applies the rule for that slot.

The first violation stops the walk. The block reports the invalid-task-state exception vector together with a 16-bit error code that identifies the offending selector. If every slot passes, it reports success with vector and code both zero. The result is announced with a one-cycle completion pulse and stays on the outputs until the next accepted start. Loading the registers, changing privilege and dispatching the exception are left to the surrounding logic.

Top module: `tss_validity_checker`

## Requirements
- R1: After reset `done`, `fault`, `busy` and `rd_req` are 0, and `vector` and `err_code` are 0.
- R2: A run whose captured `tss_limit` is below 103 faults without issuing any table read. `vector` is 0x0A and `err_code` has bits 15..1 equal to zero and bit 0 equal to the captured `ext_event`.
- R3: Slots are checked in the order local-table selector, stack, code, DS, ES, FS, GS, and only the first failing slot is reported. Exactly one table read is issued for each slot that is reached, is not skipped and passes its selector screen.
- R4: The slot bounds rule works as follows. The highest descriptor byte is index*8+7. A selector with TI=0 (bit 2) is out of bounds when that byte exceeds `gdt_limit`. A selector with TI=1 is out of bounds when no local table was loaded in this run, or when that byte exceeds the limit field of the loaded local-table descriptor.
- R5: Local-table slot: a null selector (bits 15..2 zero) is skipped. The slot fails if TI=1, if the selector is out of bounds, or if its descriptor is not present with `rd_system`=1 and `rd_type`=0010. On a pass, the descriptor's limit becomes the local table limit.
- R6: Stack slot: the slot fails if the selector is null or out of bounds. It also fails unless the descriptor is a data segment (`rd_system`=0, type bit 3 = 0) that is writable (type bit 1 = 1), has DPL equal to the new CPL, and has selector RPL equal to the new CPL. The new CPL is the RPL (bits 1..0) of the code selector.
- R7: Code slot: the slot fails if the selector is null or out of bounds, or if the descriptor is not a code segment (`rd_system`=0, type bit 3 = 1). It also fails if the segment is non-conforming (type bit 2 = 0) and its DPL differs from the new CPL, or conforming (type bit 2 = 1) and its DPL exceeds the new CPL.
- R8: DS/ES/FS/GS slots: a null selector is skipped without a read. The slot fails when out of bounds, when `rd_system`=1, or when the descriptor is a code segment without the readable bit (type bit 1). Data segments always pass.
- R9: A slot failure sets `fault`, sets `vector` to 0x0A and builds `err_code` as selector bits 15..3 in bits 15..3, the selector's TI in bit 2, 0 in bit 1 (the entry never comes from the interrupt table) and the captured `ext_event` in bit 0. The selector RPL is dropped.
- R10: `done` is high for exactly one cycle per run. `fault`, `vector` and `err_code` hold their values from that cycle until the next accepted start, which clears them.
- R11: A `start` pulse that arrives while `busy` is high is ignored, and the run in progress completes with its own captured inputs.
- R12: While `rd_req` is high and `rd_ack` is low, `rd_req`, `rd_ti` and `rd_index` keep their values. `rd_req` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a check run (accepted when idle) |
| ext_event | input | 1 | Run happens while an external event or exception is handled |
| tss_limit | input | LIM_W | Limit of the incoming task-state segment |
| gdt_limit | input | LIM_W | Global descriptor table limit |
| sel_ldt | input | 16 | Local descriptor table selector |
| sel_ss | input | 16 | Stack selector |
| sel_cs | input | 16 | Code selector |
| sel_ds | input | 16 | DS selector |
| sel_es | input | 16 | ES selector |
| sel_fs | input | 16 | FS selector |
| sel_gs | input | 16 | GS selector |
| rd_req | output | 1 | Descriptor read request |
| rd_ti | output | 1 | Table select of the read (1 = local table) |
| rd_index | output | 13 | Descriptor index of the read |
| rd_ack | input | 1 | Read response valid |
| rd_present | input | 1 | Descriptor present flag |
| rd_system | input | 1 | Descriptor is a system descriptor |
| rd_type | input | 4 | Descriptor type field |
| rd_dpl | input | 2 | Descriptor privilege level |
| rd_limit | input | LIM_W | Descriptor limit field |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last run found a violation |
| vector | output | 8 | 0x0A on fault, else 0 |
| err_code | output | 16 | Error code of the last fault, else 0 |

## Verification
The bench uses the default 20-bit limit width. It models a 13-entry global table (limit 103) that holds data, code, conforming, local-table and other system descriptors, plus a 4-entry local table. With that table size, every global index from 0 to 14 can be swept in each slot with both TI values and all four RPLs, so the exact first-out-of-bounds index and the no-local-table case are both reached. Task limits 100 to 106 straddle the 103 threshold. A delayed-acknowledge mode exercises the read handshake, and each run's result is compared with an arithmetic model of the rules that also predicts the read count.

// File: rtl/tss_chk_pkg.sv
// Package: shared types for the task-state validity checker.
// Assumes selectors are 16 bits wide with index in 15..3, TI in bit 2, RPL in 1..0.
package tss_chk_pkg;

    // Slot order of the walk; the numeric order is the check order.
    typedef enum logic [2:0] {
        STG_LDT = 3'd0,
        STG_SS  = 3'd1,
        STG_CS  = 3'd2,
        STG_DS  = 3'd3,
        STG_ES  = 3'd4,
        STG_FS  = 3'd5,
        STG_GS  = 3'd6
    } stage_e;

    localparam int NUM_SLOTS = 7;
    localparam int SEL_W     = 16;
    localparam int IDX_W     = 13;

    // Control states of the walk.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LIMIT,
        ST_STEP,
        ST_FETCH
    } walk_e;

    // System type code of a local descriptor table descriptor.
    localparam logic [3:0] LDT_SYS_TYPE = 4'b0010;

endpackage

// File: rtl/tss_sel_screen.sv
// Module: selector screen. Decides, without any table read, whether the
// current slot is skipped (null where allowed) or fails on the selector alone
// (null where forbidden, wrong table, out of bounds).
// Assumes LIM_W >= 16 so the highest descriptor byte offset fits.
module tss_sel_screen
    import tss_chk_pkg::*;
#(
    parameter int LIM_W = 20
) (
    input  stage_e             stage,
    input  logic [SEL_W-1:0]   sel,
    input  logic [LIM_W-1:0]   gdt_limit,
    input  logic               ldt_valid,
    input  logic [LIM_W-1:0]   ldt_limit,
    output logic               skip,
    output logic               pre_fail
);

    localparam int PAD_W = LIM_W - 16;

    logic             is_null;
    logic [LIM_W-1:0] top_byte;
    logic             beyond;

    // Highest byte of the descriptor and its bounds test against the chosen table.
    always_comb begin
        is_null  = (sel[SEL_W-1:2] == '0);
        top_byte = {{PAD_W{1'b0}}, sel[SEL_W-1:3], 3'b111};
        if (sel[2]) begin
            beyond = !ldt_valid || (top_byte > ldt_limit);
        end else begin
            beyond = (top_byte > gdt_limit);
        end
    end

    // Slot-specific skip and failure decisions.
    always_comb begin
        unique case (stage)
            STG_LDT: begin
                skip     = is_null;
                pre_fail = !is_null && (sel[2] || beyond);
            end
            STG_SS, STG_CS: begin
                skip     = 1'b0;
                pre_fail = is_null || beyond;
            end
            default: begin
                skip     = is_null;
                pre_fail = !is_null && beyond;
            end
        endcase
    end

endmodule

// File: rtl/tss_desc_rules.sv
// Module: descriptor rules. Combinational pass/fail of a fetched descriptor
// for the current slot, given the new CPL and the selector RPL.
// Assumes type bit 3 = code, code bit 2 = conforming, bit 1 = readable/writable.
module tss_desc_rules
    import tss_chk_pkg::*;
(
    input  stage_e       stage,
    input  logic         present,
    input  logic         system,
    input  logic [3:0]   dtype,
    input  logic [1:0]   dpl,
    input  logic [1:0]   rpl,
    input  logic [1:0]   cpl,
    output logic         desc_ok
);

    logic is_code;
    logic is_data;

    // Segment class of the descriptor.
    always_comb begin
        is_code = !system && dtype[3];
        is_data = !system && !dtype[3];
    end

    // Rule selection by slot.
    always_comb begin
        unique case (stage)
            STG_LDT: desc_ok = present && system && (dtype == LDT_SYS_TYPE);
            STG_SS:  desc_ok = is_data && dtype[1] && (dpl == cpl) && (rpl == cpl);
            STG_CS:  desc_ok = is_code && (dtype[2] ? (dpl <= cpl) : (dpl == cpl));
            default: desc_ok = is_data || (is_code && dtype[1]);
        endcase
    end

endmodule

// File: rtl/tss_err_code.sv
// Module: error code former. Produces the code for a selector failure and
// for a failure with no selector (selector field zero).
// Assumes the failing entry never comes from the interrupt table.
module tss_err_code
    import tss_chk_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             ext,
    output logic [15:0]      code_sel,
    output logic [15:0]      code_none
);

    // Index and TI copied, interrupt-table bit clear, external bit last.
    always_comb begin
        code_sel  = {sel[SEL_W-1:3], sel[2], 1'b0, ext};
        code_none = {15'd0, ext};
    end

endmodule

// File: rtl/tss_walk_ctrl.sv
// Module: walk controller. Captures the inputs on an accepted start, checks
// the task limit, then steps through the seven slots, issuing one table read
// per screened slot and stopping at the first failure. Holds the result.
// Assumes the screen, rule and code-forming logic are combinational.
module tss_walk_ctrl
    import tss_chk_pkg::*;
#(
    parameter int          LIM_W   = 20,
    parameter int          MIN_LIM = 103,
    parameter logic [7:0]  VEC     = 8'h0A
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          ext_event,
    input  logic [LIM_W-1:0]              tss_limit,
    input  logic [LIM_W-1:0]              gdt_limit,
    input  logic [NUM_SLOTS-1:0][SEL_W-1:0] sel_in,
    input  logic                          rd_ack,
    input  logic [LIM_W-1:0]              rd_limit,
    input  logic                          skip,
    input  logic                          pre_fail,
    input  logic                          desc_ok,
    input  logic [15:0]                   code_sel,
    input  logic [15:0]                   code_none,
    output stage_e                        stage,
    output logic [SEL_W-1:0]              cur_sel,
    output logic [LIM_W-1:0]              gdt_lim_q,
    output logic                          ldt_valid,
    output logic [LIM_W-1:0]              ldt_lim,
    output logic [1:0]                    cpl,
    output logic                          ext_q,
    output logic                          rd_req,
    output logic                          busy,
    output logic                          done,
    output logic                          fault,
    output logic [7:0]                    vector,
    output logic [15:0]                   err_code
);

    walk_e                          state_q;
    stage_e                         stage_q;
    logic [NUM_SLOTS-1:0][SEL_W-1:0] sel_q;
    logic [LIM_W-1:0]               tss_lim_q;
    logic [LIM_W-1:0]               gdt_q;
    logic                           ext_r;
    logic                           ldt_ok_q;
    logic [LIM_W-1:0]               ldt_lim_q;
    logic                           done_q;
    logic                           fault_q;
    logic [7:0]                     vec_q;
    logic [15:0]                    code_q;
    logic                           last_slot;

    // Current-slot view for the combinational helpers.
    always_comb begin
        stage     = stage_q;
        cur_sel   = sel_q[stage_q];
        gdt_lim_q = gdt_q;
        ldt_valid = ldt_ok_q;
        ldt_lim   = ldt_lim_q;
        cpl       = sel_q[STG_CS][1:0];
        ext_q     = ext_r;
        last_slot = (stage_q == STG_GS);
        rd_req    = (state_q == ST_FETCH);
        busy      = (state_q != ST_IDLE);
        done      = done_q;
        fault     = fault_q;
        vector    = vec_q;
        err_code  = code_q;
    end

    // Walk state machine, captured inputs and held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            stage_q   <= STG_LDT;
            sel_q     <= '0;
            tss_lim_q <= '0;
            gdt_q     <= '0;
            ext_r     <= 1'b0;
            ldt_ok_q  <= 1'b0;
            ldt_lim_q <= '0;
            done_q    <= 1'b0;
            fault_q   <= 1'b0;
            vec_q     <= '0;
            code_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sel_q     <= sel_in;
                        tss_lim_q <= tss_limit;
                        gdt_q     <= gdt_limit;
                        ext_r     <= ext_event;
                        ldt_ok_q  <= 1'b0;
                        ldt_lim_q <= '0;
                        stage_q   <= STG_LDT;
                        fault_q   <= 1'b0;
                        vec_q     <= '0;
                        code_q    <= '0;
                        state_q   <= ST_LIMIT;
                    end
                end
                ST_LIMIT: begin
                    if (tss_lim_q < LIM_W'(MIN_LIM)) begin
                        done_q  <= 1'b1;
                        fault_q <= 1'b1;
                        vec_q   <= VEC;
                        code_q  <= code_none;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    if (skip) begin
                        if (last_slot) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            stage_q <= stage_e'(stage_q + 3'd1);
                        end
                    end else if (pre_fail) begin
                        done_q  <= 1'b1;
                        fault_q <= 1'b1;
                        vec_q   <= VEC;
                        code_q  <= code_sel;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (rd_ack) begin
                        if (!desc_ok) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            vec_q   <= VEC;
                            code_q  <= code_sel;
                            state_q <= ST_IDLE;
                        end else begin
                            if (stage_q == STG_LDT) begin
                                ldt_ok_q  <= 1'b1;
                                ldt_lim_q <= rd_limit;
                            end
                            if (last_slot) begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end else begin
                                stage_q <= stage_e'(stage_q + 3'd1);
                                state_q <= ST_STEP;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tss_validity_checker.sv
// Module: top of the task-state validity checker. Ties the walk controller to
// the selector screen, descriptor rules and error code former, and exposes the
// descriptor read port.
// Assumes the table responder keeps the descriptor fields valid while rd_ack is high.
module tss_validity_checker
    import tss_chk_pkg::*;
#(
    parameter int         LIM_W   = 20,
    parameter int         MIN_LIM = 103,
    parameter logic [7:0] VEC     = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ext_event,
    input  logic [LIM_W-1:0]  tss_limit,
    input  logic [LIM_W-1:0]  gdt_limit,
    input  logic [15:0]       sel_ldt,
    input  logic [15:0]       sel_ss,
    input  logic [15:0]       sel_cs,
    input  logic [15:0]       sel_ds,
    input  logic [15:0]       sel_es,
    input  logic [15:0]       sel_fs,
    input  logic [15:0]       sel_gs,
    output logic              rd_req,
    output logic              rd_ti,
    output logic [12:0]       rd_index,
    input  logic              rd_ack,
    input  logic              rd_present,
    input  logic              rd_system,
    input  logic [3:0]        rd_type,
    input  logic [1:0]        rd_dpl,
    input  logic [LIM_W-1:0]  rd_limit,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [7:0]        vector,
    output logic [15:0]       err_code
);

    logic [NUM_SLOTS-1:0][SEL_W-1:0] sel_vec;
    stage_e                          stage;
    logic [SEL_W-1:0]                cur_sel;
    logic [LIM_W-1:0]                gdt_lim_q;
    logic                            ldt_valid;
    logic [LIM_W-1:0]                ldt_lim;
    logic [1:0]                      cpl;
    logic                            ext_q;
    logic                            skip;
    logic                            pre_fail;
    logic                            desc_ok;
    logic [15:0]                     code_sel;
    logic [15:0]                     code_none;

    // Selector vector in slot order; the index is the check order.
    always_comb begin
        sel_vec[STG_LDT] = sel_ldt;
        sel_vec[STG_SS]  = sel_ss;
        sel_vec[STG_CS]  = sel_cs;
        sel_vec[STG_DS]  = sel_ds;
        sel_vec[STG_ES]  = sel_es;
        sel_vec[STG_FS]  = sel_fs;
        sel_vec[STG_GS]  = sel_gs;
    end

    // Read address is the current selector.
    always_comb begin
        rd_ti    = cur_sel[2];
        rd_index = cur_sel[SEL_W-1:3];
    end

    tss_walk_ctrl #(
        .LIM_W   (LIM_W),
        .MIN_LIM (MIN_LIM),
        .VEC     (VEC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ext_event (ext_event),
        .tss_limit (tss_limit),
        .gdt_limit (gdt_limit),
        .sel_in    (sel_vec),
        .rd_ack    (rd_ack),
        .rd_limit  (rd_limit),
        .skip      (skip),
        .pre_fail  (pre_fail),
        .desc_ok   (desc_ok),
        .code_sel  (code_sel),
        .code_none (code_none),
        .stage     (stage),
        .cur_sel   (cur_sel),
        .gdt_lim_q (gdt_lim_q),
        .ldt_valid (ldt_valid),
        .ldt_lim   (ldt_lim),
        .cpl       (cpl),
        .ext_q     (ext_q),
        .rd_req    (rd_req),
        .busy      (busy),
        .done      (done),
        .fault     (fault),
        .vector    (vector),
        .err_code  (err_code)
    );

    tss_sel_screen #(
        .LIM_W (LIM_W)
    ) u_screen (
        .stage     (stage),
        .sel       (cur_sel),
        .gdt_limit (gdt_lim_q),
        .ldt_valid (ldt_valid),
        .ldt_limit (ldt_lim),
        .skip      (skip),
        .pre_fail  (pre_fail)
    );

    tss_desc_rules u_rules (
        .stage   (stage),
        .present (rd_present),
        .system  (rd_system),
        .dtype   (rd_type),
        .dpl     (rd_dpl),
        .rpl     (cur_sel[1:0]),
        .cpl     (cpl),
        .desc_ok (desc_ok)
    );

    tss_err_code u_code (
        .sel       (cur_sel),
        .ext       (ext_q),
        .code_sel  (code_sel),
        .code_none (code_none)
    );

endmodule

// File: rtl/tss_validity_checker_sva.sv
// Module: assertion checker for the task-state validity checker, bound to the top.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module tss_validity_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        rd_req,
    input logic        rd_ti,
    input logic [12:0] rd_index,
    input logic        rd_ack,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic [7:0]  vector,
    input logic [15:0] err_code
);

    // Completion is a single-cycle pulse.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Result only moves on completion or right after a start.
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(start)) |-> ($stable(err_code) && $stable(fault) && $stable(vector)));

    // A fault always carries the invalid-task-state vector.
    assert_fault_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (vector == 8'h0A));

    // No fault means vector and code both clear.
    assert_clean_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> ((vector == 8'h00) && (err_code == 16'h0000)));

    // Read request and address held until acknowledged.
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_index) && $stable(rd_ti)));

    // Reads only during a run.
    assert_req_in_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

endmodule

bind tss_validity_checker tss_validity_checker_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_req   (rd_req),
    .rd_ti    (rd_ti),
    .rd_index (rd_index),
    .rd_ack   (rd_ack),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .vector   (vector),
    .err_code (err_code)
);

// File: tb/test_tss_validity_checker.sv
// Bench: sweeps selectors over a small descriptor table model and compares each
// run with an arithmetic model of the slot rules.
module test_tss_validity_checker;

    localparam int CLK_PERIOD = 10;
    localparam int LIM_W      = 20;
    localparam int GDT_LIM    = 103;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              ext_event = 1'b0;
    logic [LIM_W-1:0]  tss_limit = '0;
    logic [LIM_W-1:0]  gdt_limit = LIM_W'(GDT_LIM);
    logic [15:0]       tb_sel [7];
    logic              rd_req, rd_ti, rd_ack;
    logic [12:0]       rd_index;
    logic              rd_present, rd_system;
    logic [3:0]        rd_type;
    logic [1:0]        rd_dpl;
    logic [LIM_W-1:0]  rd_limit;
    logic              busy, done, fault;
    logic [7:0]        vector;
    logic [15:0]       err_code;

    // Descriptor table models (global and local), 16 entries each.
    logic              g_p [16];
    logic              g_s [16];
    logic [3:0]        g_t [16];
    logic [1:0]        g_d [16];
    logic [LIM_W-1:0]  g_l [16];
    logic              l_p [16];
    logic              l_s [16];
    logic [3:0]        l_t [16];
    logic [1:0]        l_d [16];
    logic [LIM_W-1:0]  l_l [16];

    int checks = 0;
    int errors = 0;
    int ack_delay = 0;
    int wait_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tss_validity_checker #(.LIM_W(LIM_W)) i_tss_validity_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_event(ext_event),
        .tss_limit(tss_limit), .gdt_limit(gdt_limit),
        .sel_ldt(tb_sel[0]), .sel_ss(tb_sel[1]), .sel_cs(tb_sel[2]),
        .sel_ds(tb_sel[3]), .sel_es(tb_sel[4]), .sel_fs(tb_sel[5]), .sel_gs(tb_sel[6]),
        .rd_req(rd_req), .rd_ti(rd_ti), .rd_index(rd_index), .rd_ack(rd_ack),
        .rd_present(rd_present), .rd_system(rd_system), .rd_type(rd_type),
        .rd_dpl(rd_dpl), .rd_limit(rd_limit),
        .busy(busy), .done(done), .fault(fault), .vector(vector), .err_code(err_code)
    );

    // Table responder with programmable acknowledge delay.
    always_ff @(posedge clk) begin
        if (!rd_req || rd_ack) wait_cnt <= 0;
        else                   wait_cnt <= wait_cnt + 1;
    end

    always_comb begin
        rd_ack = rd_req && (wait_cnt >= ack_delay);
        rd_present = 1'b0; rd_system = 1'b0; rd_type = '0; rd_dpl = '0; rd_limit = '0;
        if (rd_index < 13'd16) begin
            if (rd_ti) begin
                rd_present = l_p[rd_index[3:0]]; rd_system = l_s[rd_index[3:0]];
                rd_type = l_t[rd_index[3:0]]; rd_dpl = l_d[rd_index[3:0]]; rd_limit = l_l[rd_index[3:0]];
            end else begin
                rd_present = g_p[rd_index[3:0]]; rd_system = g_s[rd_index[3:0]];
                rd_type = g_t[rd_index[3:0]]; rd_dpl = g_d[rd_index[3:0]]; rd_limit = g_l[rd_index[3:0]];
            end
        end
    end

    function automatic logic [15:0] mk(int idx, int ti, int rpl);
        return {13'(idx), 1'(ti), 2'(rpl)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Rule model: expected fault, error code and read count for the current inputs.
    task automatic ref_model(output logic f, output logic [15:0] c, output int n);
        logic lv;
        logic [LIM_W-1:0] llim;
        logic [1:0] cpl;
        f = 1'b0; c = '0; n = 0; lv = 1'b0; llim = '0; cpl = tb_sel[2][1:0];
        if (tss_limit < LIM_W'(103)) begin
            f = 1'b1; c = {15'd0, ext_event};
            return;
        end
        for (int k = 0; k < 7; k++) begin
            logic [15:0] s;
            logic nul, oob, ok, p, sy;
            logic [3:0] t;
            logic [1:0] d;
            logic [LIM_W-1:0] lm, top;
            int ix;
            s = tb_sel[k];
            ix = int'(s[15:3]);
            nul = (s[15:2] == 14'd0);
            top = LIM_W'({s[15:3], 3'b111});
            oob = s[2] ? (!lv || top > llim) : (top > gdt_limit);
            if (nul && (k == 0 || k >= 3)) continue;
            if (nul || (k == 0 && s[2]) || oob) begin
                f = 1'b1; c = {s[15:3], s[2], 1'b0, ext_event};
                return;
            end
            n++;
            if (s[2]) begin p = l_p[ix]; sy = l_s[ix]; t = l_t[ix]; d = l_d[ix]; lm = l_l[ix]; end
            else      begin p = g_p[ix]; sy = g_s[ix]; t = g_t[ix]; d = g_d[ix]; lm = g_l[ix]; end
            case (k)
                0: ok = p && sy && (t == 4'b0010);
                1: ok = !sy && !t[3] && t[1] && (d == cpl) && (s[1:0] == cpl);
                2: ok = !sy && t[3] && (t[2] ? (d <= cpl) : (d == cpl));
                default: ok = !sy && (!t[3] || t[1]);
            endcase
            if (!ok) begin
                f = 1'b1; c = {s[15:3], s[2], 1'b0, ext_event};
                return;
            end
            if (k == 0) begin lv = 1'b1; llim = lm; end
        end
    endtask

    // One complete run with comparison against the model.
    task automatic run_case(input string tag);
        logic ef;
        logic [15:0] ec;
        int en, nf, cyc;
        ref_model(ef, ec, en);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        nf = 0; cyc = 0;
        while (!done && cyc < 200) begin
            if (rd_req && rd_ack) nf++;
            @(negedge clk); cyc++;
        end
        chk(cyc < 200, {tag, " run completes"}, 32'(cyc), 32'd200);
        chk(fault == ef && vector == (ef ? 8'h0A : 8'h00), {tag, " fault/vector R9"},
            {23'd0, fault, vector}, {23'd0, ef, (ef ? 8'h0A : 8'h00)});
        chk(err_code == ec, {tag, " error code R9"}, 32'(err_code), 32'(ec));
        chk(nf == en, {tag, " read count R3"}, 32'(nf), 32'(en));
        @(negedge clk);
        chk(!done && fault == ef && err_code == ec, {tag, " result held R10"},
            {15'd0, done, err_code}, {16'd0, ec});
    endtask

    task automatic set_g(input int i, input logic p, input logic s, input logic [3:0] t,
                         input logic [1:0] d, input logic [LIM_W-1:0] l);
        g_p[i] = p; g_s[i] = s; g_t[i] = t; g_d[i] = d; g_l[i] = l;
    endtask

    task automatic base_sel();
        tb_sel[0] = 16'h0; tb_sel[1] = mk(1, 0, 0); tb_sel[2] = mk(3, 0, 0);
        tb_sel[3] = 16'h0; tb_sel[4] = 16'h0; tb_sel[5] = 16'h0; tb_sel[6] = 16'h0;
        tss_limit = LIM_W'(103);
    endtask

    // Global watchdog.
    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            set_g(i, 1'b0, 1'b0, 4'h0, 2'd0, '0);
            l_p[i] = 1'b0; l_s[i] = 1'b0; l_t[i] = '0; l_d[i] = '0; l_l[i] = '0;
        end
        set_g(1,  1'b1, 1'b0, 4'b0010, 2'd0, '0);
        set_g(2,  1'b1, 1'b0, 4'b0000, 2'd0, '0);
        set_g(3,  1'b1, 1'b0, 4'b1010, 2'd0, '0);
        set_g(4,  1'b1, 1'b0, 4'b1000, 2'd0, '0);
        set_g(5,  1'b1, 1'b0, 4'b1110, 2'd0, '0);
        set_g(6,  1'b1, 1'b0, 4'b0010, 2'd3, '0);
        set_g(7,  1'b1, 1'b0, 4'b1010, 2'd3, '0);
        set_g(8,  1'b1, 1'b0, 4'b1110, 2'd3, '0);
        set_g(9,  1'b1, 1'b1, 4'b0010, 2'd0, LIM_W'(31));
        set_g(10, 1'b0, 1'b1, 4'b0010, 2'd0, LIM_W'(31));
        set_g(11, 1'b1, 1'b1, 4'b1001, 2'd0, LIM_W'(103));
        set_g(12, 1'b1, 1'b0, 4'b0010, 2'd2, '0);
        l_p[1] = 1'b1; l_t[1] = 4'b0010; l_d[1] = 2'd3;
        l_p[2] = 1'b1; l_t[2] = 4'b1010; l_d[2] = 2'd3;
        l_p[3] = 1'b1; l_t[3] = 4'b0000; l_d[3] = 2'd3;
        base_sel();

        repeat (3) @(negedge clk);
        chk(!done && !fault && !busy && !rd_req && vector == 0 && err_code == 0, "R1 reset state",
            {4'd0, done, fault, busy, rd_req, vector, err_code}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: task limit around the threshold, both external flag values.
        for (int lim = 100; lim <= 106; lim++) begin
            for (int e = 0; e < 2; e++) begin
                base_sel(); tss_limit = LIM_W'(lim); ext_event = 1'(e);
                run_case("R2 limit");
            end
        end

        // R4/R5: local table slot over indices and TI.
        for (int i = 0; i < 15; i++) begin
            for (int ti = 0; ti < 2; ti++) begin
                base_sel(); tb_sel[0] = mk(i, ti, 0); tb_sel[3] = mk(1, 1, 3);
                ext_event = 1'(i & 1);
                run_case("R4/R5 ldt slot");
            end
        end

        // R6: stack slot over indices and RPL, CPL 0 and CPL 3.
        for (int i = 0; i < 15; i++) begin
            for (int r = 0; r < 4; r++) begin
                for (int c = 0; c < 2; c++) begin
                    base_sel(); tb_sel[1] = mk(i, 0, r);
                    tb_sel[2] = (c == 0) ? mk(3, 0, 0) : mk(7, 0, 3);
                    run_case("R6 stack slot");
                end
            end
        end

        // R7: code slot over indices and RPL, stack matched to each CPL.
        for (int i = 0; i < 15; i++) begin
            for (int r = 0; r < 4; r++) begin
                base_sel(); tb_sel[2] = mk(i, 0, r);
                case (r)
                    0: tb_sel[1] = mk(1, 0, 0);
                    2: tb_sel[1] = mk(12, 0, 2);
                    3: tb_sel[1] = mk(6, 0, 3);
                    default: tb_sel[1] = mk(1, 0, 1);
                endcase
                ext_event = 1'(r & 1);
                run_case("R7 code slot");
            end
        end

        // R8/R4: each data slot over indices and TI with a local table loaded; R3 order.
        for (int j = 3; j < 7; j++) begin
            for (int i = 0; i < 15; i++) begin
                for (int ti = 0; ti < 2; ti++) begin
                    base_sel(); tb_sel[0] = mk(9, 0, 0);
                    tb_sel[j] = mk(i, ti, 1);
                    if (j < 6) tb_sel[6] = mk(2, 0, 0);
                    ext_event = 1'(ti);
                    run_case("R8 data slot");
                end
            end
        end

        // R3: several failures at once, first in order reported.
        base_sel(); tb_sel[1] = mk(2, 0, 0); tb_sel[2] = mk(4, 0, 3); tb_sel[3] = mk(11, 0, 0);
        run_case("R3 first failure");
        base_sel(); tb_sel[3] = mk(14, 0, 0); tb_sel[5] = mk(11, 0, 0);
        run_case("R3 first failure data");

        // R12: delayed acknowledge gives the same results.
        ack_delay = 2;
        base_sel(); tb_sel[0] = mk(9, 0, 0); tb_sel[4] = mk(2, 1, 0);
        run_case("R12 delayed ack pass");
        base_sel(); tb_sel[0] = mk(9, 0, 0); tb_sel[5] = mk(4, 0, 0);
        run_case("R12 delayed ack fail");
        ack_delay = 0;

        // R11: a second start during a run is ignored.
        begin
            base_sel(); tb_sel[0] = mk(9, 0, 0); ext_event = 1'b0;
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk(busy, "R11 busy after start", 32'(busy), 32'd1);
            @(negedge clk);
            tss_limit = LIM_W'(10); ext_event = 1'b1; start = 1'b1;
            @(negedge clk); start = 1'b0;
            for (int cyc = 0; cyc < 100 && !done; cyc++) @(negedge clk);
            chk(done && !fault && err_code == 16'h0 && vector == 8'h0, "R11 restart ignored",
                {15'd0, fault, err_code}, 32'd0);
            @(negedge clk);
            chk(!busy, "R11 idle after run", 32'(busy), 32'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule